// File: doc/BRIEF.md
# Asynchronous Bus Write Master

This block is a bus master that performs one write transfer at a time on an asynchronous bus with a 32-bit address and a 16-bit data path. A requester offers an address, a 4-bit address-space code, a 2-bit operand size and the write data. The block accepts them only while it is idle. It then steps through six half-clock states, S0 to S5, and drives the bus strobes in sequence.

Even half-states begin on a rising clock edge and odd half-states begin on a falling edge. The address and the qualifiers go out first. The address strobe follows half a clock later. The data appears next, and the data strobe follows it. The two active-low acknowledge lines from the slave are resynchronized on falling edges. Wait states are added for as long as both lines read high. After an acknowledge, the block releases both strobes and then the data, and it reports completion with a one-clock pulse.

Top module: `async_wr_master`

## Requirements
- R1: While reset is held and just after it ends, bus_as_n, bus_ds_n and bus_rw_n are 1, bus_data_en is 0, req_ready is 1 and done is 0.
- R2: When req_valid is 1 at a rising edge while req_ready is 1, that edge begins S0. From that edge bus_addr, bus_fc and bus_size carry the request fields, bus_rw_n is 0 and req_ready is 0.
- R3: bus_as_n goes to 0 at the falling edge that follows S0 (S1). It stays 0 through S2, S3, every wait state and S4.
- R4: At the next rising edge (S2), bus_data_en goes to 1 and bus_data carries the request data. Both hold until the bus is released.
- R5: bus_ds_n goes to 0 at the falling edge that ends S2 (S3). It stays 0 through every wait state and S4.
- R6: bus_ack_n is captured on falling edges through SYNC_STAGES flops, which reset to 2'b11. At each rising edge that ends S3 or a wait state, the block moves to S4 if the last synchronizer stage has any bit at 0. Otherwise it adds one clock of wait state. With ack asserted from a falling edge j clocks after acceptance, done rises max(2, j+SYNC_STAGES)+1 clocks after acceptance.
- R7: At the falling edge that ends S4 (S5), bus_as_n and bus_ds_n return to 1. At the next rising edge, bus_data_en goes to 0, bus_rw_n goes to 1 and req_ready goes to 1. done is 1 for exactly that one clock.
- R8: A request that arrives while req_ready is 0 is ignored. bus_addr, bus_fc, bus_size and bus_data keep the values of the running transfer.
- R9: The acknowledge values 2'b01, 2'b10 and 2'b00 each end the cycle with the same timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_addr | input | AW | Address of the request |
| req_fc | input | 4 | Address-space code of the request |
| req_size | input | 2 | Operand size code of the request |
| req_data | input | DW | Write data of the request |
| done | output | 1 | One-clock pulse when the bus is released |
| bus_addr | output | AW | Address bus |
| bus_fc | output | 4 | Address-space code outputs |
| bus_rw_n | output | 1 | Read/write, 0 = write, 1 when idle |
| bus_size | output | 2 | Operand size outputs |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_ds_n | output | 1 | Data strobe, active low |
| bus_data | output | DW | Write data bus |
| bus_data_en | output | 1 | Data bus driver enable |
| bus_ack_n | input | 2 | Acknowledge lines from the slave, active low |

## Verification
The bench builds the block with its defaults: AW = 32, DW = 16 and SYNC_STAGES = 2. With a two-stage synchronizer, an acknowledge that is already present at acceptance still gives the minimum three-clock cycle, and a late acknowledge adds a wait state for each clock of delay. Both the no-wait path and the wait-state path of R6 are therefore reachable. Each acknowledge pattern is applied, and requests are also issued while a transfer is running.

// File: rtl/async_wr_master.sv
module async_wr_master #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_fc,
  input  logic [1:0]    req_size,
  input  logic [DW-1:0] req_data,
  output logic          done,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_fc,
  output logic          bus_rw_n,
  output logic [1:0]    bus_size,
  output logic          bus_as_n,
  output logic          bus_ds_n,
  output logic [DW-1:0] bus_data,
  output logic          bus_data_en,
  input  logic [1:0]    bus_ack_n
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S01,
    ST_S23,
    ST_WAIT,
    ST_S45
  } state_t;

  state_t st;
  logic [SYNC_STAGES-1:0][1:0] ack_sync;
  logic ack_seen;
  logic as_q, ds_q;

  assign ack_seen = ~&ack_sync[SYNC_STAGES-1];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_sync <= '1;
    end else begin
      ack_sync[0] <= bus_ack_n;
      for (int i = 1; i < SYNC_STAGES; i++) ack_sync[i] <= ack_sync[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      bus_addr <= '0;
      bus_fc   <= '0;
      bus_size <= '0;
      bus_data <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st       <= ST_S01;
          bus_addr <= req_addr;
          bus_fc   <= req_fc;
          bus_size <= req_size;
          bus_data <= req_data;
        end
        ST_S01: st <= ST_S23;
        ST_S23, ST_WAIT: st <= ack_seen ? ST_S45 : ST_WAIT;
        ST_S45: begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q <= 1'b1;
      ds_q <= 1'b1;
    end else begin
      as_q <= !(st == ST_S01 || st == ST_S23 || st == ST_WAIT);
      ds_q <= !(st == ST_S23 || st == ST_WAIT);
    end
  end

  assign bus_as_n    = as_q;
  assign bus_ds_n    = ds_q;
  assign req_ready   = (st == ST_IDLE);
  assign bus_rw_n    = (st == ST_IDLE);
  assign bus_data_en = (st == ST_S23 || st == ST_WAIT || st == ST_S45);

  p_ds_within_as_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> !bus_as_n);
  p_data_under_ds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ds_n |-> bus_data_en);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rw_n && !bus_data_en));
  p_hold_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(bus_addr) && $stable(bus_data)));
  p_as_writes_r3: assert property (@(negedge clk) disable iff (!rst_n)
    !bus_as_n |-> !bus_rw_n);

endmodule

// File: tb/async_wr_master_bench.sv
`timescale 1ns/1ps
module async_wr_master_bench;
  localparam int AW = 32, DW = 16, SYNC = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_fc = '0;
  logic [1:0] req_size = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0] bus_ack_n = 2'b11;
  logic req_ready, done, bus_rw_n, bus_as_n, bus_ds_n, bus_data_en;
  logic [AW-1:0] bus_addr;
  logic [3:0] bus_fc;
  logic [1:0] bus_size;
  logic [DW-1:0] bus_data;

  async_wr_master #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC)) u_async_wr_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_fc(req_fc), .req_size(req_size), .req_data(req_data),
    .done(done), .bus_addr(bus_addr), .bus_fc(bus_fc), .bus_rw_n(bus_rw_n),
    .bus_size(bus_size), .bus_as_n(bus_as_n), .bus_ds_n(bus_ds_n),
    .bus_data(bus_data), .bus_data_en(bus_data_en), .bus_ack_n(bus_ack_n));

  always #10 clk = ~clk;

  int vectors = 0, fails = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // reference model: half-state index, -1 = idle
  int hs = -1;
  logic m_done = 0;
  logic [AW-1:0] m_addr = '0;
  logic [3:0] m_fc = '0;
  logic [1:0] m_size = '0;
  logic [DW-1:0] m_data = '0;
  logic [1:0] ackq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs = -1; m_done = 0; m_addr = '0; m_fc = '0; m_size = '0; m_data = '0;
    end else begin
      m_done = 0;
      if (hs == -1) begin
        if (req_valid) begin
          hs = 0; m_addr = req_addr; m_fc = req_fc; m_size = req_size; m_data = req_data;
        end
      end else if (hs == 1) hs = 2;
      else if (hs == 3) begin
        if (ackq[ackq.size()-SYNC] != 2'b11) hs = 4;
      end else if (hs == 5) begin
        hs = -1; m_done = 1;
      end
    end
  end

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ackq.delete();
      for (int i = 0; i < 4; i++) ackq.push_back(2'b11);
    end else begin
      ackq.push_back(bus_ack_n);
      if (ackq.size() > 8) void'(ackq.pop_front());
      if (hs == 0 || hs == 2 || hs == 4) hs = hs + 1;
    end
  end

  task automatic compare_all;
    chk("R2", "bus_rw_n", bus_rw_n, hs < 0);
    chk("R2", "req_ready", req_ready, hs < 0);
    chk("R3", "bus_as_n", bus_as_n, !(hs >= 1 && hs <= 4));
    chk("R5", "bus_ds_n", bus_ds_n, !(hs == 3 || hs == 4));
    chk("R4", "bus_data_en", bus_data_en, hs >= 2);
    chk("R7", "done", done, m_done);
    chk("R8", "bus_addr", bus_addr, m_addr);
    chk("R8", "bus_fc", bus_fc, m_fc);
    chk("R8", "bus_size", bus_size, m_size);
    if (hs >= 2) chk("R4", "bus_data", bus_data, m_data);
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #5 compare_all;
      #10 compare_all;
    end
  end

  // one transfer; ack of pattern pat driven j clocks after acceptance
  task automatic run_write(string tag, int j, logic [1:0] pat, logic [AW-1:0] a,
                           logic [DW-1:0] d, bit poke_busy);
    int n, expn;
    @(posedge clk); #2;
    req_valid = 1; req_addr = a; req_data = d; req_fc = a[3:0]; req_size = a[5:4];
    @(posedge clk); #2;
    req_valid = 0;
    if (j <= 0) bus_ack_n = pat;
    n = 0;
    while (n < 100) begin
      if (poke_busy && n == 1) begin
        req_valid = 1; req_addr = ~a; req_data = ~d;
      end
      if (n == j && j > 0) bus_ack_n = pat;
      @(posedge clk); #5;
      n++;
      if (poke_busy && n == 2) req_valid = 0;
      if (done) break;
    end
    expn = ((j + SYNC) > 2 ? (j + SYNC) : 2) + 1;
    chk(tag, "clocks to done", n, expn);
    #2 bus_ack_n = 2'b11;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1", "as_n in reset", bus_as_n, 1);
    chk("R1", "ds_n in reset", bus_ds_n, 1);
    chk("R1", "rw_n in reset", bus_rw_n, 1);
    chk("R1", "data_en in reset", bus_data_en, 0);
    chk("R1", "ready in reset", req_ready, 1);
    chk("R1", "done in reset", done, 0);
    #5 rst_n = 1;
    @(posedge clk); #5;
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "as_n after reset", bus_as_n, 1);
    run_write("R9", 0, 2'b00, 32'h1234_5678, 16'hA55A, 0);
    run_write("R9", 0, 2'b01, 32'hDEAD_BEEF, 16'h0F0F, 0);
    run_write("R9", 0, 2'b10, 32'h0000_0011, 16'hFFFF, 0);
    run_write("R6", 3, 2'b10, 32'h8000_0000, 16'h1357, 0);
    run_write("R6", 1, 2'b00, 32'h0C0C_0C0C, 16'h2468, 0);
    run_write("R6", 6, 2'b01, 32'h7777_0001, 16'h0001, 0);
    run_write("R8", 2, 2'b00, 32'h4242_4242, 16'hBEEF, 1);
    run_write("R2", 0, 2'b00, 32'hFFFF_FFFF, 16'h0000, 0);
    repeat (4) @(posedge clk);
    #5 chk("R7", "ready at end", req_ready, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule